// File: doc/BRIEF.md
# Default data-access protection checker

This block checks every data access from two address generator ports of a processor. It applies the fixed protection rules that stay in force when page-descriptor protection is turned off. Each port gives an address, a direction flag and a valid strobe. A single mode input says whether the processor runs in user or supervisor mode. An access that breaks a rule is blocked: its grant stays low, so a store never reaches memory and a load never writes its destination. One cycle later the block raises an exception request with cause code 0x23.

The rules cover the memory-mapped register region, which is every address at or above the parameter `REG_BASE` (default 0xFFC00000). A user-mode access to that region faults on either port. An access to that region through port 1 faults even in supervisor mode. Port 0 in supervisor mode is allowed in, so a fault handler can read the captured state. Accesses outside the region are always granted.

On a fault the block captures the full byte address and a three-bit status word. A fault handler reads both through a small read port selected by `reg_sel`.

Top module: `dprot_checker`

## Requirements
- R1: A valid user-mode access on port 0 whose address is at or above `REG_BASE` is refused (`p0_grant` low in the same cycle), for both reads and writes. Address `REG_BASE` itself faults.
- R2: A valid access on port 1 whose address is at or above `REG_BASE` is refused (`p1_grant` low) in both user and supervisor mode.
- R3: A valid access on port 0 in supervisor mode is granted, whatever its address. Any valid access below `REG_BASE` (for example `REG_BASE`-4) is granted on either port in either mode.
- R4: In the cycle after any refused access, `exc_req` is 1 and `exc_cause` is 0x23. After a cycle with no refused access, `exc_req` is 0 and `exc_cause` is 0.
- R5: On a fault, the full byte address of the refused access is captured. It is read on `reg_rdata` with `reg_sel`=0 from the cycle after the fault onward.
- R6: On a fault, a status word is captured and read, zero-extended, on `reg_rdata` with `reg_sel`=1. Its bits are:
  - bit 0: 1 for a write, 0 for a read
  - bit 1: 1 for port 1, 0 for port 0
  - bit 2: 1 for user mode, 0 for supervisor mode
- R7: When both ports fault in the same cycle, both are refused, and the captured address and status describe the port 0 access.
- R8: After reset, the fault address and the status read as 0. They change only on a fault and otherwise keep their last value.
- R9: A port whose valid strobe is low is never granted and never causes a fault, even with a register-region address in user mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| user_mode | input | 1 | 1 = user mode, 0 = supervisor mode |
| p0_valid | input | 1 | Port 0 access strobe |
| p0_addr | input | ADDR_W | Port 0 byte address |
| p0_write | input | 1 | Port 0 direction, 1 = store |
| p1_valid | input | 1 | Port 1 access strobe |
| p1_addr | input | ADDR_W | Port 1 byte address |
| p1_write | input | 1 | Port 1 direction, 1 = store |
| p0_grant | output | 1 | Port 0 access may proceed |
| p1_grant | output | 1 | Port 1 access may proceed |
| exc_req | output | 1 | Exception request, one cycle per faulting cycle |
| exc_cause | output | 6 | Cause code while `exc_req` is high, else 0 |
| reg_sel | input | 1 | Read select: 0 fault address, 1 status |
| reg_rdata | output | ADDR_W | Selected captured value |

## Verification
The assertions assume that `user_mode`, the valid strobes, the addresses and the direction flags hold steady for a whole clock cycle. They also assume these inputs carry known values whenever a strobe is high, because the grant, exception and capture checks all compare same-cycle port values with the registered state one edge later. The bench changes every input only on the falling edge and keeps it for the full cycle. It returns the strobes to zero between scenarios, so each fault, hold and priority case starts from a clean cycle with no refused access.

// File: rtl/dprot_checker.sv
module dprot_checker #(
  parameter int          ADDR_W   = 32,
  parameter logic [31:0] REG_BASE = 32'hFFC0_0000,
  parameter logic [5:0]  CAUSE    = 6'h23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              user_mode,
  input  logic              p0_valid,
  input  logic [ADDR_W-1:0] p0_addr,
  input  logic              p0_write,
  input  logic              p1_valid,
  input  logic [ADDR_W-1:0] p1_addr,
  input  logic              p1_write,
  output logic              p0_grant,
  output logic              p1_grant,
  output logic              exc_req,
  output logic [5:0]        exc_cause,
  input  logic              reg_sel,
  output logic [ADDR_W-1:0] reg_rdata
);
  localparam int ST_W = 3;
  localparam logic [ADDR_W-1:0] BASE = REG_BASE[ADDR_W-1:0];

  logic              p0_in_reg, p1_in_reg;
  logic              p0_fault, p1_fault, any_fault;
  logic [ADDR_W-1:0] fault_addr_q;
  logic [ST_W-1:0]   status_q;
  logic [ST_W-1:0]   status_d;
  logic [ADDR_W-1:0] addr_d;

  assign p0_in_reg = p0_addr >= BASE;
  assign p1_in_reg = p1_addr >= BASE;

  assign p0_fault  = p0_valid && p0_in_reg && user_mode;
  assign p1_fault  = p1_valid && p1_in_reg;
  assign any_fault = p0_fault || p1_fault;

  assign p0_grant = p0_valid && !p0_fault;
  assign p1_grant = p1_valid && !p1_fault;

  assign addr_d   = p0_fault ? p0_addr : p1_addr;
  assign status_d = p0_fault ? {user_mode, 1'b0, p0_write}
                             : {user_mode, 1'b1, p1_write};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_req   <= 1'b0;
      exc_cause <= '0;
    end else begin
      exc_req   <= any_fault;
      exc_cause <= any_fault ? CAUSE : 6'h00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_addr_q <= '0;
      status_q     <= '0;
    end else if (any_fault) begin
      fault_addr_q <= addr_d;
      status_q     <= status_d;
    end
  end

  assign reg_rdata = reg_sel ? {{(ADDR_W-ST_W){1'b0}}, status_q} : fault_addr_q;

  p_user_p0_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_valid && user_mode && p0_addr >= BASE) |-> !p0_grant);

  p_p1_blocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (p1_valid && p1_addr >= BASE) |-> !p1_grant);

  p_sup_p0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_valid && !user_mode) |-> p0_grant);

  p_exc_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((p0_valid && !p0_grant) || (p1_valid && !p1_grant)) |=> (exc_req && exc_cause == CAUSE));

  p_exc_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !((p0_valid && !p0_grant) || (p1_valid && !p1_grant)) |=> (!exc_req && exc_cause == 6'h00));

  p_prio_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_valid && !p0_grant) |=> (fault_addr_q == $past(p0_addr) && !status_q[1]));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !((p0_valid && !p0_grant) || (p1_valid && !p1_grant)) |=> ($stable(fault_addr_q) && $stable(status_q)));

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!p0_grant || p0_valid) && (!p1_grant || p1_valid));
endmodule

// File: tb/dprot_checker_tb.sv
module dprot_checker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        user_mode = 1'b0;
  logic        p0_valid = 1'b0, p0_write = 1'b0;
  logic        p1_valid = 1'b0, p1_write = 1'b0;
  logic [31:0] p0_addr = '0, p1_addr = '0;
  logic        p0_grant, p1_grant, exc_req;
  logic [5:0]  exc_cause;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_rdata;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dprot_checker u_dut (
    .clk(clk), .rst_n(rst_n), .user_mode(user_mode),
    .p0_valid(p0_valid), .p0_addr(p0_addr), .p0_write(p0_write),
    .p1_valid(p1_valid), .p1_addr(p1_addr), .p1_write(p1_write),
    .p0_grant(p0_grant), .p1_grant(p1_grant),
    .exc_req(exc_req), .exc_cause(exc_cause),
    .reg_sel(reg_sel), .reg_rdata(reg_rdata)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_regs(output logic [31:0] fa, output logic [31:0] st);
    reg_sel = 1'b0; #1 fa = reg_rdata;
    reg_sel = 1'b1; #1 st = reg_rdata;
    reg_sel = 1'b0;
  endtask

  task automatic apply(input logic um,
                       input logic v0, input logic [31:0] a0, input logic w0,
                       input logic v1, input logic [31:0] a1, input logic w1,
                       input logic eg0, input logic eg1);
    @(negedge clk);
    user_mode = um;
    p0_valid = v0; p0_addr = a0; p0_write = w0;
    p1_valid = v1; p1_addr = a1; p1_write = w1;
    #1;
    check("grant0", {31'b0, p0_grant}, {31'b0, eg0});
    check("grant1", {31'b0, p1_grant}, {31'b0, eg1});
    @(negedge clk);
    p0_valid = 1'b0; p1_valid = 1'b0;
  endtask

  task automatic expect_after(string req, logic ex, logic [31:0] efa, logic [31:0] est);
    logic [31:0] fa, st;
    check({req, " R4 exc_req"}, {31'b0, exc_req}, {31'b0, ex});
    check({req, " R4 exc_cause"}, {26'b0, exc_cause}, ex ? 32'h23 : 32'h0);
    read_regs(fa, st);
    check({req, " R5 fault addr"}, fa, efa);
    check({req, " R6 status"}, st, est);
  endtask

  task automatic t_reset;
    logic [31:0] fa, st;
    check("R8 reset exc_req", {31'b0, exc_req}, 32'h0);
    check("R8 reset cause", {26'b0, exc_cause}, 32'h0);
    read_regs(fa, st);
    check("R8 reset addr", fa, 32'h0);
    check("R8 reset status", st, 32'h0);
  endtask

  task automatic t_user_p0_write;
    apply(1, 1, 32'hFFC0_0100, 1, 0, 0, 0, 0, 0);
    expect_after("R1 user p0 write", 1, 32'hFFC0_0100, 32'h5);
  endtask

  task automatic t_user_p0_low;
    apply(1, 1, 32'h0000_1000, 0, 0, 0, 0, 1, 0);
    expect_after("R3 R8 user p0 low hold", 0, 32'hFFC0_0100, 32'h5);
  endtask

  task automatic t_boundary;
    apply(1, 1, 32'hFFBF_FFFC, 0, 1, 32'hFFBF_FFFC, 1, 1, 1);
    expect_after("R3 below base", 0, 32'hFFC0_0100, 32'h5);
    apply(1, 1, 32'hFFC0_0000, 0, 0, 0, 0, 0, 0);
    expect_after("R1 at base read", 1, 32'hFFC0_0000, 32'h4);
  endtask

  task automatic t_sup_p0;
    apply(0, 1, 32'hFFC0_0004, 0, 0, 0, 0, 1, 0);
    expect_after("R3 sup p0 region", 0, 32'hFFC0_0000, 32'h4);
  endtask

  task automatic t_sup_p1;
    apply(0, 0, 0, 0, 1, 32'hFFE0_0000, 1, 0, 0);
    expect_after("R2 sup p1 write", 1, 32'hFFE0_0000, 32'h3);
  endtask

  task automatic t_user_p1;
    apply(1, 0, 0, 0, 1, 32'hFFC0_0010, 0, 0, 0);
    expect_after("R2 user p1 read", 1, 32'hFFC0_0010, 32'h6);
  endtask

  task automatic t_both;
    apply(1, 1, 32'hFFC0_0020, 0, 1, 32'hFFD0_0000, 1, 0, 0);
    expect_after("R7 both fault", 1, 32'hFFC0_0020, 32'h4);
  endtask

  task automatic t_invalid;
    apply(1, 0, 32'hFFC0_0040, 1, 0, 32'hFFC0_0080, 1, 0, 0);
    expect_after("R9 invalid strobes", 0, 32'hFFC0_0020, 32'h4);
  endtask

  task automatic t_sup_p0_then_p1;
    apply(0, 1, 32'hFFC0_0008, 1, 1, 32'hFFC0_000C, 0, 1, 0);
    expect_after("R2 R3 sup mixed", 1, 32'hFFC0_000C, 32'h2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_user_p0_write();
    t_user_p0_low();
    t_boundary();
    t_sup_p0();
    t_sup_p1();
    t_user_p1();
    t_both();
    t_invalid();
    t_sup_p0_then_p1();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule